// File: doc/BRIEF.md
# Multi-Cycle 32-bit RISC-V Subset Core

This block is a small 32-bit RISC-V integer core. Every instruction runs as a series of short steps, and a controller state machine sequences them. The fetch step reads the instruction word and moves the program counter on by four. The decode step reads the two source registers. The execute step does the arithmetic, the compare or the jump-target work. Only loads, stores and instructions that write a register go on to further steps. Each instruction therefore takes as few cycles as its class allows.

The core has one memory port, and it serves both instructions and data. In the fetch step the port carries the program counter. In the memory steps of a load or a store it carries the computed data address. The port is word-addressed, and its read data must be valid in the same cycle as its address. The register file, the ALU, the immediate builder and the holding registers between steps are all inside the block. The memory itself is outside.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the core presents a fetch of word address `RESET_PC[31:2]`, with `mem_ifetch`=1 and `mem_we`=0.
- R2: Register-register add, sub, and, or and slt (signed less-than, giving 1 or 0) give correct results. Each takes 4 cycles from one fetch to the next. All instructions use the standard RV32I encodings (opcode in bits 6:0, rd in 11:7, funct3 in 14:12, rs1 in 19:15, rs2 in 24:20, bit 30 choosing sub).
- R3: addi, xori and slti use a sign-extended 12-bit immediate and take 4 cycles.
- R4: A word load reads the word at rs1 plus a signed offset, writes it to rd and takes 5 cycles.
- R5: A word store writes rs2 to the word at rs1 plus a signed offset. `mem_we` is high for exactly one cycle, and the store takes 4 cycles.
- R6: beq, bne, blt and bge (signed) take 3 cycles. When the condition holds, the next fetch is at the branch address plus the offset. Otherwise it is at the branch address plus 4.
- R7: jal writes its own address plus 4 to rd, jumps to its address plus the offset, and takes 4 cycles.
- R8: jalr writes its own address plus 4 to rd, jumps to rs1 plus the offset with bit 0 cleared, and takes 4 cycles.
- R9: lui writes the 20-bit immediate shifted left by 12 to rd and takes 4 cycles.
- R10: Register x0 always reads zero, and a write to x0 has no effect.
- R11: The one memory port carries fetches and data accesses in different cycles. `mem_ifetch` is high only in fetch cycles. `mem_addr` is the byte address with bits 1:0 dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Word address of the shared memory |
| mem_rdata | input | XLEN | Read data for `mem_addr`, valid in the same cycle |
| mem_wdata | output | XLEN | Store data |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| mem_ifetch | output | 1 | High when the port access is an instruction fetch |

## Verification
Nearly any wrong internal state shows at the port within one instruction. A wrong next state changes the spacing between fetch pulses, and that spacing is compared per instruction against its class length. A wrong program counter shows at once as a wrong fetch address, at the very next fetch. A wrong register value or ALU result stays hidden until a store copies it out. For that reason, every computed value in the program is stored soon after it is produced, so a fault shows at most a few instructions later.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [2:0] {
      S_FETCH, S_DECODE, S_EXEC, S_MEMRD, S_MEMWR, S_WBMEM, S_WBALU
   } state_t;

   typedef enum logic [3:0] {
      C_RTYPE, C_ITYPE, C_LOAD, C_STORE, C_BRANCH, C_JAL, C_JALR, C_LUI, C_BAD
   } iclass_t;

   typedef enum logic [2:0] {
      A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLT
   } aluop_t;

   typedef enum logic [2:0] {
      K_I, K_S, K_B, K_J, K_U
   } immk_t;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  aluop_t            op,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   output logic [XLEN-1:0]   y,
   output logic              eq,
   output logic              lt
);

   always_comb begin
      eq = (a == b);
      lt = ($signed(a) < $signed(b));
      unique case (op)
         A_ADD:   y = a + b;
         A_SUB:   y = a - b;
         A_AND:   y = a & b;
         A_OR:    y = a | b;
         A_XOR:   y = a ^ b;
         A_SLT:   y = {{(XLEN-1){1'b0}}, lt};
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/mc_immgen.sv
module mc_immgen
   import mc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]       ir,
   input  immk_t             kind,
   output logic [XLEN-1:0]   imm
);

   always_comb begin
      unique case (kind)
         K_I:     imm = {{20{ir[31]}}, ir[31:20]};
         K_S:     imm = {{20{ir[31]}}, ir[31:25], ir[11:7]};
         K_B:     imm = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
         K_J:     imm = {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
         K_U:     imm = {ir[31:12], 12'b0};
         default: imm = '0;
      endcase
   end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int XLEN     = 32,
   parameter int NREG     = 32,
   parameter bit RF_RESET = 1'b1,
   localparam int RIW     = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RIW-1:0]    ra1,
   input  logic [RIW-1:0]    ra2,
   input  logic [RIW-1:0]    wa,
   input  logic              we,
   input  logic [XLEN-1:0]   wd,
   output logic [XLEN-1:0]   rd1,
   output logic [XLEN-1:0]   rd2
);

   logic [XLEN-1:0] rf_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign rf_q[g] = '0;
      end else begin : g_live
         logic [XLEN-1:0] q;
         logic            hit;
         assign hit = we && (wa == RIW'(g));
         if (RF_RESET) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   q <= '0;
               else if (hit) q <= wd;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (hit) q <= wd;
            end
         end
         assign rf_q[g] = q;
      end
   end

   assign rd1 = rf_q[ra1];
   assign rd2 = rf_q[ra2];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] ir,
   input  logic        eq,
   input  logic        lt,
   output state_t      state,
   output iclass_t     cls,
   output aluop_t      aluop,
   output immk_t       immk,
   output logic        br_taken
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic       f7b;
   state_t     state_d;

   assign opc = ir[6:0];
   assign f3  = ir[14:12];
   assign f7b = ir[30];

   always_comb begin
      cls   = C_BAD;
      aluop = A_ADD;
      immk  = K_I;
      unique case (opc)
         OPC_REG: begin
            cls = C_RTYPE;
            unique case (f3)
               3'b000:  aluop = f7b ? A_SUB : A_ADD;
               3'b111:  aluop = A_AND;
               3'b110:  aluop = A_OR;
               3'b100:  aluop = A_XOR;
               3'b010:  aluop = A_SLT;
               default: aluop = A_ADD;
            endcase
         end
         OPC_IMM: begin
            cls = C_ITYPE;
            unique case (f3)
               3'b100:  aluop = A_XOR;
               3'b010:  aluop = A_SLT;
               default: aluop = A_ADD;
            endcase
         end
         OPC_LOAD:   cls = C_LOAD;
         OPC_STORE:  begin cls = C_STORE;  immk = K_S; end
         OPC_BRANCH: begin cls = C_BRANCH; immk = K_B; aluop = A_SUB; end
         OPC_JAL:    begin cls = C_JAL;    immk = K_J; end
         OPC_JALR:   cls = C_JALR;
         OPC_LUI:    begin cls = C_LUI;    immk = K_U; end
         default:    cls = C_BAD;
      endcase
   end

   always_comb begin
      unique case (f3)
         3'b000:  br_taken = eq;
         3'b001:  br_taken = !eq;
         3'b100:  br_taken = lt;
         3'b101:  br_taken = !lt;
         default: br_taken = 1'b0;
      endcase
   end

   always_comb begin
      state_d = state;
      unique case (state)
         S_FETCH:  state_d = S_DECODE;
         S_DECODE: state_d = (cls == C_BAD) ? S_FETCH : S_EXEC;
         S_EXEC: begin
            unique case (cls)
               C_LOAD:   state_d = S_MEMRD;
               C_STORE:  state_d = S_MEMWR;
               C_BRANCH: state_d = S_FETCH;
               default:  state_d = S_WBALU;
            endcase
         end
         S_MEMRD:  state_d = S_WBMEM;
         S_MEMWR:  state_d = S_FETCH;
         S_WBMEM:  state_d = S_FETCH;
         S_WBALU:  state_d = S_FETCH;
         default:  state_d = S_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_FETCH;
      else        state <= state_d;
   end

   AST_BRANCH_ENDS_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_EXEC && cls == C_BRANCH) |=> (state == S_FETCH)); // R6
   AST_LOAD_GOES_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MEMRD) |=> (state == S_WBMEM)); // R4
   AST_STORE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MEMWR) |=> (state == S_FETCH)); // R5

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              NREG     = 32,
   parameter int              ADDR_W   = 30,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter bit              RF_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic [XLEN-1:0]   mem_wdata,
   output logic              mem_we,
   output logic              mem_ifetch
);

   localparam int RIW = $clog2(NREG);

   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_core: XLEN must be 32");
   end
   if (NREG != 16 && NREG != 32) begin : g_bad_nreg
      $error("mc_core: NREG must be 16 or 32");
   end
   if (ADDR_W < 2 || ADDR_W > XLEN - 2) begin : g_bad_aw
      $error("mc_core: ADDR_W out of range");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("mc_core: RESET_PC must be word aligned");
   end

   state_t          state;
   iclass_t         cls;
   aluop_t          aluop;
   immk_t           immk;
   logic            br_taken;

   logic [XLEN-1:0] pc_q, oldpc_q, a_q, b_q, alu_q, mdr_q;
   logic [31:0]     ir_q;
   logic [XLEN-1:0] imm, srca, srcb, alu_y, target, rd1, rd2, wd;
   logic            eq, lt, link, jump_tk, rf_we;

   mc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ir       (ir_q),
      .eq       (eq),
      .lt       (lt),
      .state    (state),
      .cls      (cls),
      .aluop    (aluop),
      .immk     (immk),
      .br_taken (br_taken)
   );

   mc_immgen #(.XLEN(XLEN)) u_imm (
      .ir   (ir_q),
      .kind (immk),
      .imm  (imm)
   );

   assign srca = (cls == C_LUI) ? '0 : a_q;
   assign srcb = (cls == C_RTYPE || cls == C_BRANCH) ? b_q : imm;

   mc_alu #(.XLEN(XLEN)) u_alu (
      .op (aluop),
      .a  (srca),
      .b  (srcb),
      .y  (alu_y),
      .eq (eq),
      .lt (lt)
   );

   assign rf_we = (state == S_WBMEM) || (state == S_WBALU);
   assign wd    = (state == S_WBMEM) ? mdr_q : alu_q;

   mc_regfile #(.XLEN(XLEN), .NREG(NREG), .RF_RESET(RF_RESET)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (ir_q[15 +: RIW]),
      .ra2   (ir_q[20 +: RIW]),
      .wa    (ir_q[7 +: RIW]),
      .we    (rf_we),
      .wd    (wd),
      .rd1   (rd1),
      .rd2   (rd2)
   );

   assign target  = oldpc_q + imm;
   assign link    = (cls == C_JAL) || (cls == C_JALR);
   assign jump_tk = (cls == C_JAL) || (cls == C_BRANCH && br_taken);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= RESET_PC;
         oldpc_q <= '0;
         ir_q    <= '0;
         a_q     <= '0;
         b_q     <= '0;
         alu_q   <= '0;
         mdr_q   <= '0;
      end else begin
         unique case (state)
            S_FETCH: begin
               ir_q    <= mem_rdata[31:0];
               oldpc_q <= pc_q;
               pc_q    <= pc_q + XLEN'(4);
            end
            S_DECODE: begin
               a_q <= rd1;
               b_q <= rd2;
            end
            S_EXEC: begin
               alu_q <= link ? pc_q : alu_y;
               if (jump_tk)          pc_q <= target;
               else if (cls == C_JALR) pc_q <= alu_y & ~XLEN'(1);
            end
            S_MEMRD: mdr_q <= mem_rdata;
            default: ;
         endcase
      end
   end

   assign mem_ifetch = (state == S_FETCH);
   assign mem_addr   = mem_ifetch ? pc_q[2 +: ADDR_W] : alu_q[2 +: ADDR_W];
   assign mem_wdata  = b_q;
   assign mem_we     = (state == S_MEMWR);

   AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R11
   AST_JALR_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_EXEC && cls == C_JALR) |=> (pc_q[0] == 1'b0)); // R8

endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [29:0] mem_addr;
   logic [31:0] mem_rdata, mem_wdata;
   logic        mem_we, mem_ifetch;

   logic [31:0] mem [256];

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] fq_pc  [$];
   int          fq_cyc [$];
   string       fq_tag [$];
   logic [31:0] sq_addr [$];
   logic [31:0] sq_data [$];
   string       sq_tag  [$];

   int    wp = 0;
   int    cyc = 0;
   int    prev_cyc = 0;
   int    prev_exp = 0;
   string prev_tag = "";
   bit    have_prev = 1'b0;
   bit    all_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mc_core u_mc_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .mem_ifetch (mem_ifetch)
   );

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd);
      return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
      logic [31:0] v;
      v = imm;
      return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
   endfunction
   function automatic logic [31:0] enc_s(int imm, int rs2, int rs1);
      logic [31:0] v;
      v = imm;
      return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_b(int imm, int rs2, int rs1, int f3);
      logic [31:0] v;
      v = imm;
      return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:1], v[11], 7'b1100011};
   endfunction
   function automatic logic [31:0] enc_j(int imm, int rd);
      logic [31:0] v;
      v = imm;
      return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
   endfunction
   function automatic logic [31:0] enc_u(int imm20, int rd);
      logic [31:0] v;
      v = imm20;
      return {v[19:0], 5'(rd), 7'b0110111};
   endfunction

   // driver: place an instruction and, if it runs, queue its fetch and length
   task automatic emit(input logic [31:0] ins, input int len, input bit runs, input string tag);
      mem[wp] = ins;
      if (runs) begin
         fq_pc.push_back(32'(wp * 4));
         fq_cyc.push_back(len);
         fq_tag.push_back(tag);
      end
      wp++;
   endtask

   task automatic exp_store(input logic [31:0] baddr, input logic [31:0] data, input string tag);
      sq_addr.push_back(baddr);
      sq_data.push_back(data);
      sq_tag.push_back(tag);
   endtask

   // monitor: pop and compare as the core produces fetches and stores
   always @(negedge clk) begin
      if (rst_n && !all_done) begin
         cyc++;
         if (mem_ifetch) begin
            if (have_prev)
               chk((cyc - prev_cyc) == prev_exp, prev_tag, "cycles per instruction",
                   32'(cyc - prev_cyc), 32'(prev_exp));
            if (fq_pc.size() > 0) begin
               logic [31:0] epc;
               epc = fq_pc.pop_front();
               prev_exp = fq_cyc.pop_front();
               prev_tag = fq_tag.pop_front();
               chk(mem_addr == epc[31:2], prev_tag, "fetch address (R11)",
                   {mem_addr, 2'b00}, epc);
               chk(!mem_we, "R11", "write during fetch", 32'(mem_we), 32'd0);
               have_prev = 1'b1;
               prev_cyc = cyc;
            end else begin
               all_done = 1'b1;
            end
         end
         if (mem_we) begin
            if (sq_addr.size() > 0) begin
               logic [31:0] ea, ed;
               string       et;
               ea = sq_addr.pop_front();
               ed = sq_data.pop_front();
               et = sq_tag.pop_front();
               chk(mem_addr == ea[31:2], et, "store address (R5)", {mem_addr, 2'b00}, ea);
               chk(mem_wdata == ed, et, "store data", mem_wdata, ed);
            end else begin
               chk(1'b0, "R5", "unexpected store", {mem_addr, 2'b00}, 32'd0);
            end
         end
      end
   end

   initial begin
      int waited;
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;

      emit(enc_i(5, 0, 0, 1, 7'b0010011), 4, 1, "R3 addi");         // 0  x1=5
      emit(enc_i(-3, 0, 0, 2, 7'b0010011), 4, 1, "R3 addi neg");    // 1  x2=-3
      emit(enc_r(0, 2, 1, 0, 3), 4, 1, "R2 add");                   // 2
      emit(enc_s(32'h200, 3, 0), 4, 1, "R5 sw");                    // 3
      emit(enc_r(32, 2, 1, 0, 4), 4, 1, "R2 sub");                  // 4
      emit(enc_s(32'h204, 4, 0), 4, 1, "R5 sw");                    // 5
      emit(enc_r(0, 2, 1, 7, 5), 4, 1, "R2 and");                   // 6
      emit(enc_s(32'h208, 5, 0), 4, 1, "R5 sw");                    // 7
      emit(enc_r(0, 2, 1, 6, 6), 4, 1, "R2 or");                    // 8
      emit(enc_s(32'h20C, 6, 0), 4, 1, "R5 sw");                    // 9
      emit(enc_r(0, 1, 2, 2, 7), 4, 1, "R2 slt true");              // 10
      emit(enc_r(0, 2, 1, 2, 8), 4, 1, "R2 slt false");             // 11
      emit(enc_s(32'h210, 7, 0), 4, 1, "R5 sw");                    // 12
      emit(enc_s(32'h214, 8, 0), 4, 1, "R5 sw");                    // 13
      emit(enc_i(-1, 1, 4, 9, 7'b0010011), 4, 1, "R3 xori");        // 14
      emit(enc_s(32'h218, 9, 0), 4, 1, "R5 sw");                    // 15
      emit(enc_i(-2, 2, 2, 10, 7'b0010011), 4, 1, "R3 slti");       // 16
      emit(enc_s(32'h21C, 10, 0), 4, 1, "R5 sw");                   // 17
      emit(enc_u(32'h12345, 11), 4, 1, "R9 lui");                   // 18
      emit(enc_s(32'h220, 11, 0), 4, 1, "R5 sw");                   // 19
      emit(enc_i(32'h220, 0, 2, 12, 7'b0000011), 5, 1, "R4 lw");    // 20
      emit(enc_i(1, 12, 0, 12, 7'b0010011), 4, 1, "R3 addi");       // 21
      emit(enc_s(32'h224, 12, 0), 4, 1, "R5 sw");                   // 22
      emit(enc_i(7, 1, 0, 0, 7'b0010011), 4, 1, "R10 write x0");    // 23
      emit(enc_s(32'h228, 0, 0), 4, 1, "R10 sw x0");                // 24
      emit(enc_b(8, 1, 1, 0), 3, 1, "R6 beq taken");                // 25
      emit(enc_s(32'h22C, 1, 0), 4, 0, "skipped");                  // 26
      emit(enc_b(8, 1, 1, 1), 3, 1, "R6 bne not taken");            // 27
      emit(enc_b(8, 1, 2, 4), 3, 1, "R6 blt taken");                // 28
      emit(enc_i(99, 0, 0, 13, 7'b0010011), 4, 0, "skipped");       // 29
      emit(enc_b(8, 1, 2, 5), 3, 1, "R6 bge not taken");            // 30
      emit(enc_b(8, 1, 1, 5), 3, 1, "R6 bge equal taken");          // 31
      emit(enc_s(32'h22C, 1, 0), 4, 0, "skipped");                  // 32
      emit(enc_j(8, 14), 4, 1, "R7 jal");                           // 33
      emit(enc_s(32'h22C, 1, 0), 4, 0, "skipped");                  // 34
      emit(enc_s(32'h22C, 14, 0), 4, 1, "R5 sw");                   // 35
      emit(enc_i(161, 0, 0, 15, 7'b0010011), 4, 1, "R3 addi");      // 36
      emit(enc_i(0, 15, 0, 16, 7'b1100111), 4, 1, "R8 jalr");       // 37
      emit(enc_s(32'h22C, 1, 0), 4, 0, "skipped");                  // 38
      emit(enc_s(32'h22C, 1, 0), 4, 0, "skipped");                  // 39
      emit(enc_s(32'h230, 16, 0), 4, 1, "R5 sw");                   // 40
      emit(enc_i(32'h240, 0, 0, 17, 7'b0010011), 4, 1, "R3 addi");  // 41
      emit(enc_i(-32, 17, 2, 18, 7'b0000011), 5, 1, "R4 lw neg");   // 42
      emit(enc_s(-12, 18, 17), 4, 1, "R5 sw neg");                  // 43
      emit(enc_j(0, 0), 4, 1, "R7 jal self");                       // 44
      fq_pc.push_back(32'd176); fq_cyc.push_back(4); fq_tag.push_back("R7 jal self");

      exp_store(32'h200, 32'h0000_0002, "R2 add");
      exp_store(32'h204, 32'h0000_0008, "R2 sub");
      exp_store(32'h208, 32'h0000_0005, "R2 and");
      exp_store(32'h20C, 32'hFFFF_FFFD, "R2 or");
      exp_store(32'h210, 32'h0000_0001, "R2 slt true");
      exp_store(32'h214, 32'h0000_0000, "R2 slt false");
      exp_store(32'h218, 32'hFFFF_FFFA, "R3 xori");
      exp_store(32'h21C, 32'h0000_0001, "R3 slti");
      exp_store(32'h220, 32'h1234_5000, "R9 lui");
      exp_store(32'h224, 32'h1234_5001, "R4 lw data");
      exp_store(32'h228, 32'h0000_0000, "R10 x0");
      exp_store(32'h22C, 32'h0000_0088, "R7 jal link");
      exp_store(32'h230, 32'h0000_0098, "R8 jalr link");
      exp_store(32'h234, 32'h1234_5000, "R4 lw neg offset");

      repeat (3) @(posedge clk);
      chk(mem_ifetch == 1'b1, "R1", "ifetch in reset", 32'(mem_ifetch), 32'd1);
      chk(mem_we == 1'b0, "R1", "we in reset", 32'(mem_we), 32'd0);
      #1 rst_n = 1'b1;
      #1;
      chk(mem_addr == 30'd0, "R1", "first fetch address", {mem_addr, 2'b00}, 32'd0);
      chk(mem_ifetch == 1'b1, "R1", "first cycle is fetch", 32'(mem_ifetch), 32'd1);

      waited = 0;
      while (!all_done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      #1;
      if (!all_done)
         chk(1'b0, "R11", "watchdog", 32'(waited), 32'd0);
      chk(sq_addr.size() == 0, "R5", "stores outstanding", 32'(sq_addr.size()), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule